// File: doc/BRIEF.md
# Radio Transceiver Wake-Up Sequencer

This block orders the power-up of a radio transceiver's analog blocks. It begins from a power-on event or from sleep. It turns on the crystal oscillator, then waits for the oscillator to report ready. A stability timer runs next. After that, filter tuning runs together with the band-gap and digital regulator, and a second timer must expire before the transceiver counts as idle. From idle, a command starts the analog regulator. A short timer runs, and then the PLL is enabled in either the PLL-ready state or the receive state.

The sequence stops and waits for an explicit idle command only when it was started by a power-on event. A wake from sleep runs on to idle by itself, and so does a transceiver reset. The transceiver reset is an active-low input that sends the sequence back to the filter-tuning step. The receive state can be entered from the PLL-ready state at any time, whether or not the PLL has locked. All settling timers count a one-microsecond tick enable, and their lengths are parameters. Lock and oscillator-ready come in as inputs. A one-cycle interrupt pulse reports the first PLL lock.

Top module: `radio_wake_seq`

## Requirements
- R1: When `rst` is high, the state code becomes SLEEP (0). All five enables go low and `lock_irq` goes low.
- R2: A `por_evt` pulse in any state moves the machine to XOSC (1) on the next clock and marks the sequence as started by power-on. XOSC moves to OSC_SETTLE (2) on the first clock at which `osc_ready` is high.
- R3: OSC_SETTLE lasts exactly T_OSC ticks of `tick_us`. The clock that carries the last tick moves the machine to TUNE (3).
- R4: TUNE lasts exactly T_BG ticks. It then enters POR_HOLD (4) if the sequence was started by power-on, and IDLE (5) otherwise. POR_HOLD leaves only on an idle command.
- R5: In SLEEP with `slp_pin` low, the machine wakes to XOSC and reaches IDLE with no command. In IDLE with `slp_pin` high, it returns to SLEEP.
- R6: In IDLE, a PLL-ready or receive command enters AREG_SETTLE (6) for exactly T_AREG ticks. The machine then enters PLL_READY (7) or RECEIVE (8), as the command asked.
- R7: In PLL_READY, a receive command enters RECEIVE on the next clock whatever `pll_lock` is. In RECEIVE, a PLL-ready command enters PLL_READY. An idle command in either state enters IDLE.
- R8: Any command that is not listed for the current state leaves the state unchanged. Command codes on `cmd_code`, qualified by `cmd_valid`, are: 0 none, 1 idle, 2 PLL-ready, 3 receive.
- R9: With `chip_rst_n` low in states 3 to 8, the machine enters TUNE and stays there. Its timer restarts every cycle while the input is low. After release it runs T_BG ticks and then enters IDLE.
- R10: `lock_irq` is high for one cycle, on the clock after the one at which `pll_lock` is first seen rising while `pll_en` is high. It does not pulse again until `pll_en` has gone low.
- R11: Settling timers advance only on clocks where `tick_us` is high.
- R12: `osc_en` is high in every state but SLEEP. `ftn_en` is high only in TUNE. `bgdv_en` is high in states 3 to 8. `areg_en` is high in states 6 to 8. `pll_en` is high in states 7 and 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-microsecond tick enable |
| por_evt | input | 1 | Power-on event pulse |
| slp_pin | input | 1 | Sleep request level (1 = sleep) |
| chip_rst_n | input | 1 | Transceiver reset, active low |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 2 | Command code |
| osc_ready | input | 1 | Oscillator delivers clock |
| pll_lock | input | 1 | PLL lock flag |
| osc_en | output | 1 | Oscillator enable |
| ftn_en | output | 1 | Filter tuning enable |
| bgdv_en | output | 1 | Band-gap and digital regulator enable |
| areg_en | output | 1 | Analog regulator enable |
| pll_en | output | 1 | PLL enable |
| state_code | output | 4 | Current state code |
| lock_irq | output | 1 | PLL-locked interrupt pulse |

## Verification
The sequence is driven along three paths:
- A power-on start, which must stop in POR_HOLD.
- A sleep wake, which must run through to IDLE.
- A transceiver reset, which must re-enter at TUNE and then reach IDLE.

Comparing these paths shows whether the origin of the sequence is remembered correctly. Each timed state is run with a continuous tick, and one stretch is run with the tick held low, so that off-by-one errors in a timer's length show up apart from errors in tick gating. Every command is sent in states where it is legal and in states where it is not. The lock input is toggled more than once within a single PLL session, to tell a first-edge pulse from a pulse on every edge.

// File: rtl/radio_wake_pkg.sv
package radio_wake_pkg;

    typedef enum logic [3:0] {
        ST_SLEEP = 4'd0,
        ST_XOSC  = 4'd1,
        ST_OSCT  = 4'd2,
        ST_TUNE  = 4'd3,
        ST_HOLD  = 4'd4,
        ST_IDLE  = 4'd5,
        ST_AREG  = 4'd6,
        ST_PLL   = 4'd7,
        ST_RX    = 4'd8
    } seq_state_e;

    typedef enum logic [1:0] {
        CMD_NOP  = 2'd0,
        CMD_IDLE = 2'd1,
        CMD_PLL  = 2'd2,
        CMD_RX   = 2'd3
    } cmd_e;

    typedef struct packed {
        logic osc;
        logic ftn;
        logic bgdv;
        logic areg;
        logic pll;
    } blk_en_t;

    // Oscillator is running and the transceiver reset may act
    function automatic logic osc_running(seq_state_e s);
        return s inside {ST_TUNE, ST_HOLD, ST_IDLE, ST_AREG, ST_PLL, ST_RX};
    endfunction

    function automatic blk_en_t enables_of(seq_state_e s);
        blk_en_t e;
        e.osc  = (s != ST_SLEEP);
        e.ftn  = (s == ST_TUNE);
        e.bgdv = osc_running(s);
        e.areg = s inside {ST_AREG, ST_PLL, ST_RX};
        e.pll  = s inside {ST_PLL, ST_RX};
        return e;
    endfunction

endpackage

// File: rtl/settle_timer.sv
module settle_timer #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic         tick,
    input  logic [W-1:0] len,
    output logic         done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || restart) cnt_q <= '0;
        else if (tick)      cnt_q <= cnt_q + 1'b1;
    end

    // done marks the tick that completes the programmed length
    assign done = tick && (cnt_q == len - 1'b1);
endmodule

// File: rtl/lock_pulse.sv
module lock_pulse (
    input  logic clk,
    input  logic rst,
    input  logic pll_en,
    input  logic pll_lock,
    output logic irq
);
    logic lock_q, fired_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q  <= 1'b0;
            fired_q <= 1'b0;
            irq     <= 1'b0;
        end else begin
            lock_q <= pll_lock;
            irq    <= pll_en && pll_lock && !lock_q && !fired_q;
            if (!pll_en)                          fired_q <= 1'b0;
            else if (pll_lock && !lock_q)         fired_q <= 1'b1;
        end
    end
endmodule

// File: rtl/radio_wake_seq.sv
module radio_wake_seq
    import radio_wake_pkg::*;
#(
    parameter int T_OSC  = 256,
    parameter int T_BG   = 128,
    parameter int T_AREG = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_us,
    input  logic       por_evt,
    input  logic       slp_pin,
    input  logic       chip_rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_code,
    input  logic       osc_ready,
    input  logic       pll_lock,
    output logic       osc_en,
    output logic       ftn_en,
    output logic       bgdv_en,
    output logic       areg_en,
    output logic       pll_en,
    output logic [3:0] state_code,
    output logic       lock_irq
);
    localparam int TMAX = (T_OSC > T_BG) ? ((T_OSC > T_AREG) ? T_OSC : T_AREG)
                                         : ((T_BG > T_AREG) ? T_BG : T_AREG);
    localparam int TW = $clog2(TMAX + 1);
    localparam logic [TW-1:0] LEN_OSC  = TW'(T_OSC);
    localparam logic [TW-1:0] LEN_BG   = TW'(T_BG);
    localparam logic [TW-1:0] LEN_AREG = TW'(T_AREG);

    seq_state_e   st_q, st_d;
    logic         por_q, por_d;
    logic         rx_tgt_q, rx_tgt_d;
    logic [TW-1:0] len_sel;
    logic         tmr_done, tmr_restart, hw_reset;
    logic         go_idle, go_pll, go_rx;
    blk_en_t      en;

    assign go_idle  = cmd_valid && (cmd_code == CMD_IDLE);
    assign go_pll   = cmd_valid && (cmd_code == CMD_PLL);
    assign go_rx    = cmd_valid && (cmd_code == CMD_RX);
    assign hw_reset = !chip_rst_n && osc_running(st_q);

    always_comb begin
        case (st_q)
            ST_OSCT: len_sel = LEN_OSC;
            ST_TUNE: len_sel = LEN_BG;
            default: len_sel = LEN_AREG;
        endcase
    end

    always_comb begin
        st_d     = st_q;
        por_d    = por_q;
        rx_tgt_d = rx_tgt_q;
        if (por_evt) begin
            st_d  = ST_XOSC;
            por_d = 1'b1;
        end else if (hw_reset) begin
            st_d  = ST_TUNE;
            por_d = 1'b0;
        end else begin
            case (st_q)
                ST_SLEEP: if (!slp_pin) begin
                    st_d  = ST_XOSC;
                    por_d = 1'b0;
                end
                ST_XOSC:  if (osc_ready) st_d = ST_OSCT;
                ST_OSCT:  if (tmr_done)  st_d = ST_TUNE;
                ST_TUNE:  if (tmr_done)  st_d = por_q ? ST_HOLD : ST_IDLE;
                ST_HOLD:  if (go_idle)   st_d = ST_IDLE;
                ST_IDLE: begin
                    if (slp_pin) st_d = ST_SLEEP;
                    else if (go_pll || go_rx) begin
                        st_d     = ST_AREG;
                        rx_tgt_d = go_rx;
                    end
                end
                ST_AREG:  if (tmr_done) st_d = rx_tgt_q ? ST_RX : ST_PLL;
                ST_PLL: begin
                    if (go_idle)    st_d = ST_IDLE;
                    else if (go_rx) st_d = ST_RX;
                end
                ST_RX: begin
                    if (go_idle)     st_d = ST_IDLE;
                    else if (go_pll) st_d = ST_PLL;
                end
                default: st_d = ST_SLEEP;
            endcase
        end
    end

    assign tmr_restart = (st_d != st_q) || hw_reset;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_SLEEP;
            por_q    <= 1'b0;
            rx_tgt_q <= 1'b0;
        end else begin
            st_q     <= st_d;
            por_q    <= por_d;
            rx_tgt_q <= rx_tgt_d;
        end
    end

    settle_timer #(.W(TW)) tmr_i (
        .clk     (clk),
        .rst     (rst),
        .restart (tmr_restart),
        .tick    (tick_us),
        .len     (len_sel),
        .done    (tmr_done)
    );

    assign en         = enables_of(st_q);
    assign osc_en     = en.osc;
    assign ftn_en     = en.ftn;
    assign bgdv_en    = en.bgdv;
    assign areg_en    = en.areg;
    assign pll_en     = en.pll;
    assign state_code = st_q;

    lock_pulse lk_i (
        .clk      (clk),
        .rst      (rst),
        .pll_en   (en.pll),
        .pll_lock (pll_lock),
        .irq      (lock_irq)
    );
endmodule

// File: rtl/radio_wake_seq_chk.sv
module radio_wake_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       por_evt,
    input logic       chip_rst_n,
    input logic       cmd_valid,
    input logic [1:0] cmd_code,
    input logic       osc_en,
    input logic       ftn_en,
    input logic       areg_en,
    input logic       pll_en,
    input logic [3:0] state_code,
    input logic       lock_irq
);
    // R12
    pll_needs_areg_chk: assert property (@(posedge clk) disable iff (rst)
        pll_en |-> areg_en);

    // R12
    tune_needs_osc_chk: assert property (@(posedge clk) disable iff (rst)
        ftn_en |-> osc_en);

    // R6
    pll_after_areg_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pll_en) |-> $past(areg_en));

    // R7
    rx_without_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (state_code == 4'd7 && cmd_valid && cmd_code == 2'd3 && !por_evt && chip_rst_n)
        |=> (state_code == 4'd8));

    // R8
    hold_ignores_chk: assert property (@(posedge clk) disable iff (rst)
        (state_code == 4'd4 && !por_evt && chip_rst_n && !(cmd_valid && cmd_code == 2'd1))
        |=> (state_code == 4'd4));

    // R9
    chip_reset_tune_chk: assert property (@(posedge clk) disable iff (rst)
        (!chip_rst_n && !por_evt && state_code >= 4'd3 && state_code <= 4'd8)
        |=> (state_code == 4'd3));

    // R10
    irq_single_chk: assert property (@(posedge clk) disable iff (rst)
        lock_irq |=> !lock_irq);
endmodule

bind radio_wake_seq radio_wake_seq_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .por_evt    (por_evt),
    .chip_rst_n (chip_rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_code   (cmd_code),
    .osc_en     (osc_en),
    .ftn_en     (ftn_en),
    .areg_en    (areg_en),
    .pll_en     (pll_en),
    .state_code (state_code),
    .lock_irq   (lock_irq)
);

// File: tb/radio_wake_seq_tb_top.sv
module radio_wake_seq_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_us = 1'b1, por_evt = 1'b0, slp_pin = 1'b1, chip_rst_n = 1'b1;
    logic cmd_valid = 1'b0, osc_ready = 1'b0, pll_lock = 1'b0;
    logic [1:0] cmd_code = 2'd0;
    logic osc_en, ftn_en, bgdv_en, areg_en, pll_en, lock_irq;
    logic [3:0] state_code;
    int checks = 0, errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    radio_wake_seq #(.T_OSC(3), .T_BG(2), .T_AREG(2)) dut_i (
        .clk(clk), .rst(rst), .tick_us(tick_us), .por_evt(por_evt),
        .slp_pin(slp_pin), .chip_rst_n(chip_rst_n), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .osc_ready(osc_ready), .pll_lock(pll_lock),
        .osc_en(osc_en), .ftn_en(ftn_en), .bgdv_en(bgdv_en), .areg_en(areg_en),
        .pll_en(pll_en), .state_code(state_code), .lock_irq(lock_irq)
    );

    // Vector: por slp cv cmd[2] ordy lock tick | req[4] | exp_state[4]
    localparam logic [15:0] VEC [0:29] = '{
        16'b1_0_0_00_0_0_1_0010_0001, // R2 start at XOSC
        16'b0_0_0_00_0_0_1_0010_0001, // R2 waits for osc_ready
        16'b0_0_0_00_1_0_1_0010_0010,
        16'b0_0_0_00_1_0_1_0011_0010, // R3
        16'b0_0_0_00_1_0_1_0011_0010,
        16'b0_0_0_00_1_0_1_0011_0011,
        16'b0_0_0_00_1_0_0_1011_0011, // R11 no tick
        16'b0_0_0_00_1_0_1_0100_0011, // R4
        16'b0_0_0_00_1_0_1_0100_0100,
        16'b0_0_1_10_1_0_1_1000_0100, // R8 pll cmd in hold
        16'b0_0_1_01_1_0_1_0100_0101,
        16'b0_0_1_10_1_0_1_0110_0110, // R6
        16'b0_0_0_00_1_0_1_0110_0110,
        16'b0_0_0_00_1_0_1_0110_0111,
        16'b0_0_1_11_1_0_1_0111_1000, // R7 rx without lock
        16'b0_0_1_10_1_0_1_0111_0111,
        16'b0_0_1_01_1_0_1_0111_0101,
        16'b0_0_1_11_1_0_1_0110_0110,
        16'b0_0_0_00_1_0_1_0110_0110,
        16'b0_0_0_00_1_0_1_0110_1000,
        16'b0_0_1_01_1_0_1_0111_0101,
        16'b0_1_0_00_1_0_1_0101_0000, // R5 sleep
        16'b0_1_1_11_1_0_1_1000_0000, // R8 cmd in sleep
        16'b0_0_0_00_1_0_1_0101_0001, // R5 wake
        16'b0_0_0_00_1_0_1_0101_0010,
        16'b0_0_0_00_1_0_1_0101_0010,
        16'b0_0_0_00_1_0_1_0101_0010,
        16'b0_0_0_00_1_0_1_0101_0011,
        16'b0_0_0_00_1_0_1_0101_0011,
        16'b0_0_0_00_1_0_1_0101_0101
    };

    // R12 enable table: {osc, ftn, bgdv, areg, pll}
    function automatic logic [4:0] exp_en(input logic [3:0] s);
        logic [4:0] e;
        e[4] = (s != 4'd0);
        e[3] = (s == 4'd3);
        e[2] = (s >= 4'd3 && s <= 4'd8);
        e[1] = (s >= 4'd6 && s <= 4'd8);
        e[0] = (s == 4'd7 || s == 4'd8);
        return e;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic chk_state(input string tag, input logic [3:0] s);
        chk(tag, state_code, s);
        chk({tag, " R12 enables"}, {osc_en, ftn_en, bgdv_en, areg_en, pll_en}, exp_en(s));
    endtask

    task automatic cmd_cyc(input logic [1:0] c);
        cmd_valid = 1'b1; cmd_code = c;
        cyc();
        cmd_valid = 1'b0; cmd_code = 2'd0;
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        cyc(); cyc();
        // R1 reset state
        chk_state("R1 reset", 4'd0);
        chk("R1 irq", lock_irq, 0);
        rst = 1'b0;
        slp_pin = 1'b1;
        cyc();
        chk_state("R1 stays asleep", 4'd0);

        for (int i = 0; i < 30; i++) begin
            logic [15:0] v;
            v = VEC[i];
            por_evt   = v[15];
            slp_pin   = v[14];
            cmd_valid = v[13];
            cmd_code  = v[12:11];
            osc_ready = v[10];
            pll_lock  = v[9];
            tick_us   = v[8];
            cyc();
            chk($sformatf("R%0d vector %0d", v[7:4], i), state_code, v[3:0]);
            chk($sformatf("R12 vector %0d", i),
                {osc_en, ftn_en, bgdv_en, areg_en, pll_en}, exp_en(v[3:0]));
        end
        por_evt = 1'b0; cmd_valid = 1'b0; cmd_code = 2'd0; tick_us = 1'b1;

        // R9 transceiver reset from PLL_READY
        cmd_cyc(2'd2); cyc(); cyc();
        chk_state("R9 setup pll", 4'd7);
        chip_rst_n = 1'b0;
        cyc(); chk_state("R9 enter tune", 4'd3);
        cyc(); cyc(); chk_state("R9 held in tune", 4'd3);
        chip_rst_n = 1'b1;
        cyc(); chk_state("R9 first tick", 4'd3);
        cyc(); chk_state("R9 to idle without hold", 4'd5);

        // R10 lock interrupt
        cmd_cyc(2'd2); cyc(); cyc();
        chk_state("R10 setup pll", 4'd7);
        chk("R10 no irq before lock", lock_irq, 0);
        pll_lock = 1'b1;
        cyc(); chk("R10 pulse", lock_irq, 1);
        cyc(); chk("R10 one cycle", lock_irq, 0);
        pll_lock = 1'b0; cyc();
        pll_lock = 1'b1; cyc();
        chk("R10 no second pulse", lock_irq, 0);
        cmd_cyc(2'd3);
        chk_state("R7 pll to rx", 4'd8);
        chk("R10 rx no pulse", lock_irq, 0);
        pll_lock = 1'b0;
        cmd_cyc(2'd1);
        chk_state("R7 rx to idle", 4'd5);
        cmd_cyc(2'd2); cyc(); cyc();
        pll_lock = 1'b1;
        cyc(); chk("R10 new session pulse", lock_irq, 1);

        // R8 command during analog settling ignored
        pll_lock = 1'b0;
        cmd_cyc(2'd1);
        cmd_cyc(2'd3);
        chk_state("R6 areg", 4'd6);
        cmd_cyc(2'd1);
        chk_state("R8 idle cmd in areg ignored", 4'd6);
        cyc();
        chk_state("R6 rx target", 4'd8);

        // R2 power-on event from receive
        por_evt = 1'b1; osc_ready = 1'b0;
        cyc(); por_evt = 1'b0;
        chk_state("R2 por from rx", 4'd1);

        // R1 reset mid-run
        rst = 1'b1;
        cyc(); chk_state("R1 reset mid-run", 4'd0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule